// File: doc/BRIEF.md
# Cipher Block Buffer Front End

This block is the register-mapped data path in front of a 128-bit block cipher engine. Software loads a 128-bit block one 32-bit word at a time through a single data-in address. A two-bit input word pointer picks the word to fill and then steps forward, wrapping from 3 to 0. Results come back through a single data-out address, driven by a separate output word pointer that behaves the same way. Both pointers live in one register that software can also load directly.

Which words of a block matter depends on the chaining mode and, for the feedback mode, on the segment size. The block keeps a per-word written mask and a per-word read mask. It compares them with the relevant-word mask to decide when to launch the core and when the result has been drained. Two status flags, input-ready and output-ready, each have an enable bit that gates the interrupt line. A bank of four 32-bit initial-vector words accepts full-word writes only.

The cipher itself is replaced by a stub with a request/done handshake. The stub returns each input word XORed with the matching initial-vector word, a fixed number of cycles after the request.

Top module: `blkbuf_front`

## Requirements
- R1: After reset the status register reads 1 (bit 0 input-ready = 1, bit 1 output-ready = 0), the pointer register reads 0 and `irq` is 0.
- R2: A write to the data-in address (4) stores the byte lanes enabled by `bus_be` into input word `in_ptr`. `in_ptr` then increments by one and wraps from 3 to 0. The pointer register (address 1) holds `in_ptr` in bits [1:0] and `out_ptr` in bits [5:4].
- R3: A write to the pointer register with `bus_be[0]` set loads both pointers from the write data. The next data-out read returns the word chosen by the loaded `out_ptr`.
- R4: The core is launched once every relevant input word has been written since the last launch and the core is idle. The launch sets input-ready. A write to a relevant input word clears input-ready, and this clearing wins over a launch in the same cycle.
- R5: Mode field (control register address 0, bits [2:0]): 0 ECB, 1 CBC, 2 OFB, 3 feedback, 4 counter. Segment field (bits [6:4]): 0 = 128, 1 = 64, 2 = 32, 3 = 16, 4 = 8 bits. Only in mode 3 with segment 1 are words 0 and 1 relevant, and only in mode 3 with segments 2–4 is word 0 alone relevant. In every other case all four words are relevant.
- R6: When the core finishes, output-ready sets. A read of the data-out address (5) returns output word `out_ptr`, and `out_ptr` then increments and wraps. Output-ready clears once every relevant output word has been read since the result was loaded.
- R7: `irq` is high while (input-ready AND interrupt-enable bit 0) OR (output-ready AND interrupt-enable bit 1), with the enables at address 3.
- R8: A write to an initial-vector word (addresses 8–11, word 0 first) takes effect only when all four byte strobes are set. Any other strobe pattern leaves the word unchanged.
- R9: A write to an input word that is not relevant stores the data and advances `in_ptr`. It neither counts toward a launch nor clears input-ready.
- R10: Read data for an access appears on `bus_rdata` on the cycle after the read request and holds until the next read.
- R11: If a result is loaded in the same cycle as a data-out read, the read returns the old word and still advances `out_ptr`. The read mask is cleared, so that read does not count toward draining the new result.
- R12: The core result is the input block XORed word-by-word with the initial vector. It is loaded `LAT`+2 cycles after the last relevant word is written (6 with the default `LAT` = 4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Word address of the access |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_be | input | 4 | Byte strobes for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| irq | output | 1 | Interrupt request |

## Verification
The sharp case is a data-out read landing on the very cycle the core result is loaded into the output buffer. The bench writes the last word of a block and then waits exactly five idle cycles, so that its data-out read meets the load edge. It expects that read to return the previous block's word. It then expects output-ready to stay set after the three remaining words are read, and to clear only after the skipped word is read again. The bench also checks that input-ready stays set when a non-relevant word is written.

// File: rtl/blkbuf_pkg.sv
package blkbuf_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_PTR   = 4'd1;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd2;
    localparam logic [ADDR_W-1:0] A_IRQEN = 4'd3;
    localparam logic [ADDR_W-1:0] A_DIN   = 4'd4;
    localparam logic [ADDR_W-1:0] A_DOUT  = 4'd5;
    localparam logic [ADDR_W-1:0] A_IV0   = 4'd8;

    // bit position of the output pointer inside the pointer register
    localparam int OPTR_LSB = 4;

    typedef enum logic [2:0] {
        M_ECB = 3'd0,
        M_CBC = 3'd1,
        M_OFB = 3'd2,
        M_FB  = 3'd3,
        M_CTR = 3'd4
    } mode_e;

    typedef enum logic [2:0] {
        SEG_128 = 3'd0,
        SEG_64  = 3'd1,
        SEG_32  = 3'd2,
        SEG_16  = 3'd3,
        SEG_8   = 3'd4
    } seg_e;
endpackage

// File: rtl/blkbuf_relmask.sv
module blkbuf_relmask
    import blkbuf_pkg::*;
#(
    parameter int NW = 4
) (
    input  logic [2:0]    mode,
    input  logic [2:0]    seg,
    output logic [NW-1:0] rel
);
    // R5: relevant words per mode / segment
    always_comb begin
        rel = '1;
        if (mode == 3'(M_FB)) begin
            case (seg)
                3'(SEG_64): begin
                    rel      = '0;
                    rel[1:0] = 2'b11;
                end
                3'(SEG_32), 3'(SEG_16), 3'(SEG_8): begin
                    rel    = '0;
                    rel[0] = 1'b1;
                end
                default: rel = '1;
            endcase
        end
    end
endmodule

// File: rtl/blkbuf_core_stub.sv
module blkbuf_core_stub #(
    parameter int NW  = 4,
    parameter int DW  = 32,
    parameter int LAT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [NW*DW-1:0] din,
    input  logic [NW*DW-1:0] key,
    output logic             busy,
    output logic             done,
    output logic [NW*DW-1:0] res
);
    localparam int CW = $clog2(LAT + 1);

    typedef struct packed {
        logic             busy;
        logic [CW-1:0]    cnt;
        logic             done;
        logic [NW*DW-1:0] res;
    } stub_t;

    stub_t st_d, st_q;
    logic [NW*DW-1:0] mix;

    // R12: word-wise combination of data and initial vector
    for (genvar w = 0; w < NW; w++) begin : g_mix
        assign mix[w*DW +: DW] = din[w*DW +: DW] ^ key[w*DW +: DW];
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (req) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CW'(LAT - 1);
            st_d.res  = mix;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign done = st_q.done;
    assign res  = st_q.res;

    assert_done_after_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
    assert_busy_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.cnt != '0) |=> busy);
endmodule

// File: rtl/blkbuf_front.sv
module blkbuf_front
    import blkbuf_pkg::*;
#(
    parameter int NW  = 4,
    parameter int DW  = 32,
    parameter int LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DW/8-1:0]   bus_be,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq
);
    localparam int PW = $clog2(NW);
    localparam int BW = DW / 8;

    typedef struct packed {
        logic [NW-1:0][DW-1:0] ibuf;
        logic [NW-1:0][DW-1:0] obuf;
        logic [NW-1:0][DW-1:0] iv;
        logic [PW-1:0]         iptr;
        logic [PW-1:0]         optr;
        logic [NW-1:0]         wmask;
        logic [NW-1:0]         rmask;
        logic                  ibuf_rdy;
        logic                  obuf_rdy;
        logic [1:0]            irqen;
        logic [2:0]            mode;
        logic [2:0]            seg;
        logic [DW-1:0]         rdata;
    } fe_t;

    fe_t q, n;

    logic [NW-1:0]    rel;
    logic             core_req, core_busy, core_done;
    logic [NW*DW-1:0] core_res;

    blkbuf_relmask #(.NW(NW)) u_relmask (
        .mode (q.mode),
        .seg  (q.seg),
        .rel  (rel)
    );

    blkbuf_core_stub #(.NW(NW), .DW(DW), .LAT(LAT)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (core_req),
        .din   (q.ibuf),
        .key   (q.iv),
        .busy  (core_busy),
        .done  (core_done),
        .res   (core_res)
    );

    logic wr_din, rd_dout, wr_ptr, wr_iv;
    logic [NW-1:0] ibit, obit;

    assign wr_din  = bus_wr && bus_addr == A_DIN;
    assign rd_dout = bus_rd && bus_addr == A_DOUT;
    assign wr_ptr  = bus_wr && bus_addr == A_PTR && bus_be[0];
    assign wr_iv   = bus_wr && bus_addr >= A_IV0 && bus_addr < A_IV0 + ADDR_W'(NW);
    assign ibit    = NW'(1) << q.iptr;
    assign obit    = NW'(1) << q.optr;

    // R4: launch when every relevant word is present and the core is idle
    assign core_req = ((q.wmask & rel) == rel) && !core_busy;

    always_comb begin
        n = q;

        // control registers
        if (bus_wr && bus_addr == A_CTRL && bus_be[0]) begin
            n.mode = bus_wdata[2:0];
            n.seg  = bus_wdata[6:4];
        end
        if (bus_wr && bus_addr == A_IRQEN && bus_be[0])
            n.irqen = bus_wdata[1:0];
        if (wr_ptr) begin
            n.iptr = bus_wdata[PW-1:0];
            n.optr = bus_wdata[OPTR_LSB +: PW];
        end

        // R8: initial vector takes full-word writes only
        if (wr_iv && bus_be == '1)
            n.iv[bus_addr[PW-1:0]] = bus_wdata;

        // R4: hand-off to core
        if (core_req) begin
            n.wmask    = '0;
            n.ibuf_rdy = 1'b1;
        end

        // R2 / R9: input word write
        if (wr_din) begin
            for (int b = 0; b < BW; b++) begin
                if (bus_be[b])
                    n.ibuf[q.iptr][b*8 +: 8] = bus_wdata[b*8 +: 8];
            end
            n.iptr = q.iptr + 1'b1;
            if ((rel & ibit) != '0) begin
                n.wmask    = n.wmask | ibit;
                n.ibuf_rdy = 1'b0;
            end
        end

        // R6: output word read
        if (rd_dout) begin
            n.optr  = q.optr + 1'b1;
            n.rmask = q.rmask | (obit & rel);
            if (q.obuf_rdy && (((q.rmask | obit) & rel) == rel))
                n.obuf_rdy = 1'b0;
        end

        // R11: result load wins over a read in the same cycle
        if (core_done) begin
            n.obuf     = core_res;
            n.rmask    = '0;
            n.obuf_rdy = 1'b1;
        end

        // R10: registered read data
        if (bus_rd) begin
            n.rdata = '0;
            case (bus_addr)
                A_CTRL:  n.rdata = DW'({q.seg, 1'b0, q.mode});
                A_PTR:   n.rdata = DW'({q.optr, {(OPTR_LSB - PW){1'b0}}, q.iptr});
                A_STAT:  n.rdata = DW'({q.obuf_rdy, q.ibuf_rdy});
                A_IRQEN: n.rdata = DW'(q.irqen);
                A_DOUT:  n.rdata = q.obuf[q.optr];
                default: begin
                    if (bus_addr >= A_IV0 && bus_addr < A_IV0 + ADDR_W'(NW))
                        n.rdata = q.iv[bus_addr[PW-1:0]];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.ibuf_rdy <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign bus_rdata = q.rdata;
    assign irq       = |({q.obuf_rdy, q.ibuf_rdy} & q.irqen);

    assert_inptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_din |=> q.iptr == PW'($past(q.iptr) + 1'b1));
    assert_ptr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr |=> q.optr == $past(bus_wdata[OPTR_LSB +: PW]));
    assert_launch_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && !wr_din) |=> (q.ibuf_rdy && q.wmask == '0));
    assert_iv_partial_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_iv && bus_be != '1) |=> $stable(q.iv));
    assert_rd_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_STAT) |=>
            q.rdata == DW'({$past(q.obuf_rdy), $past(q.ibuf_rdy)}));
    assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> (q.obuf_rdy && q.rmask == '0));
endmodule

// File: tb/blkbuf_front_bench.sv
module blkbuf_front_bench;
    localparam logic [3:0] CTRL = 4'd0, PTR = 4'd1, STAT = 4'd2, IRQEN = 4'd3;
    localparam logic [3:0] DIN = 4'd4, DOUT = 4'd5, IV0 = 4'd8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0, fails = 0;
    bit finished = 1'b0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    logic [31:0] iv[4];
    logic [31:0] a[4], b[4];

    always #10 clk = ~clk;

    blkbuf_front u_blkbuf_front (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // monitor: compare each read response against the scoreboard
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                fails++;
                $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic idle(input int cyc);
        repeat (cyc) begin
            @(negedge clk);
            bus_wr = 1'b0;
            bus_rd = 1'b0;
        end
    endtask

    task automatic wr(input logic [3:0] ad, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_rd = 1'b0;
        bus_addr = ad; bus_wdata = d; bus_be = be;
    endtask

    task automatic rd(input logic [3:0] ad, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b1;
        bus_addr = ad;
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic chk_irq(input logic e, input string t);
        checks++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s: irq got %b expected %b", t, irq, e);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        iv = '{32'h11112222, 32'h33334444, 32'h55556666, 32'h77778888};
        for (int i = 0; i < 4; i++) begin
            a[i] = 32'hA0A0_0000 + 32'(i * 17);
            b[i] = 32'hB0B0_0000 + 32'(i * 29);
        end
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(STAT, 32'h1, "R1 status");
        rd(PTR, 32'h0, "R1 pointers");
        idle(1);
        chk_irq(1'b0, "R1 irq");

        // R8 initial vector
        for (int i = 0; i < 4; i++) wr(IV0 + 4'(i), iv[i], 4'hF);
        wr(IV0, 32'hDEADBEEF, 4'b0011);
        wr(IV0 + 4'd1, 32'hCAFEF00D, 4'b0111);
        rd(IV0, iv[0], "R8 iv0 partial write ignored");
        rd(IV0 + 4'd1, iv[1], "R8 iv1 partial write ignored");

        // ECB block, R2/R4/R6/R7/R12
        wr(CTRL, 32'h0, 4'hF);
        wr(IRQEN, 32'h2, 4'hF);
        idle(1);
        chk_irq(1'b0, "R7 output enable only, no output");
        wr(DIN, a[0], 4'hF);
        rd(STAT, 32'h0, "R4 input-ready cleared by write");
        rd(PTR, 32'h1, "R2 input pointer step");
        for (int i = 1; i < 4; i++) wr(DIN, a[i], 4'hF);
        rd(PTR, 32'h0, "R2 input pointer wrap");
        idle(20);
        rd(STAT, 32'h3, "R4 R6 both flags after processing");
        idle(1);
        chk_irq(1'b1, "R7 output-ready interrupt");
        for (int i = 0; i < 3; i++) rd(DOUT, a[i] ^ iv[i], "R12 result word");
        rd(STAT, 32'h3, "R6 output-ready held until all read");
        rd(DOUT, a[3] ^ iv[3], "R12 result word 3");
        rd(STAT, 32'h1, "R6 output-ready cleared");
        idle(1);
        chk_irq(1'b0, "R7 interrupt drops");
        rd(PTR, 32'h0, "R6 output pointer wrap");

        // R11 result load coincides with a data-out read
        for (int i = 0; i < 4; i++) wr(DIN, b[i], 4'hF);
        idle(5);
        rd(DOUT, a[0] ^ iv[0], "R11 colliding read returns old word");
        for (int i = 1; i < 4; i++) rd(DOUT, b[i] ^ iv[i], "R11 new word");
        rd(STAT, 32'h3, "R11 colliding read not counted");
        rd(DOUT, b[0] ^ iv[0], "R11 word 0 after wrap");
        rd(STAT, 32'h1, "R6 cleared after word 0");

        wr(IRQEN, 32'h1, 4'hF);
        idle(1);
        chk_irq(1'b1, "R7 input-ready interrupt");
        wr(IRQEN, 32'h0, 4'hF);

        // 64-bit feedback: R5 R9
        wr(CTRL, 32'h13, 4'hF);
        wr(PTR, 32'h02, 4'hF);
        wr(DIN, 32'hC2C2C2C2, 4'hF);
        idle(20);
        rd(STAT, 32'h1, "R9 non-relevant write no launch");
        rd(PTR, 32'h03, "R9 pointer still advances");
        wr(PTR, 32'h00, 4'hF);
        wr(DIN, 32'hC0C0C0C0, 4'hF);
        wr(DIN, 32'hC1C1C1C1, 4'hF);
        idle(20);
        rd(STAT, 32'h3, "R5 two words launch");
        rd(DOUT, 32'hC0C0C0C0 ^ iv[0], "R5 word 0");
        rd(DOUT, 32'hC1C1C1C1 ^ iv[1], "R5 word 1");
        rd(STAT, 32'h1, "R5 two reads drain");

        // 8-bit feedback, byte strobes on data-in
        wr(CTRL, 32'h43, 4'hF);
        wr(PTR, 32'h00, 4'hF);
        wr(DIN, 32'hD0D0D0D0, 4'hF);
        wr(PTR, 32'h00, 4'hF);
        wr(DIN, 32'h000000EE, 4'b0001);
        rd(STAT, 32'h0, "R12 result not yet loaded");
        idle(20);
        rd(STAT, 32'h3, "R5 single word launch");
        rd(DOUT, 32'hD0D0D0EE ^ iv[0], "R2 byte strobe merge");
        rd(STAT, 32'h1, "R5 single read drains");

        // R3 direct pointer load
        wr(PTR, 32'h31, 4'hF);
        rd(PTR, 32'h31, "R3 pointer readback");
        rd(DOUT, b[3] ^ iv[3], "R3 read from loaded pointer");
        rd(PTR, 32'h01, "R3 output pointer wraps after load");
        rd(CTRL, 32'h43, "R10 control readback");

        idle(3);
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule